// File: doc/BRIEF.md
# Two-Source Status Packet Merger

This block lets two producers of byte-serial status packets share one downstream status link. A producer raises its request line. The merger grants the link to one requester and passes that request downstream. The downstream side answers with a one-cycle start pulse when it takes the first byte of a packet, which is the address byte. The merger hands this pulse back to the granted producer in the same cycle. The producer then drives its packet bytes, and the merger copies them to the downstream data bus.

A packet is a fixed number of cycles long, `PKT_LEN`, and the default is 5. The first byte carries the status address. The second carries a sequence number together with the two lowest status bits. The remaining bytes carry the higher status bits. The merger does not interpret any of these bytes. It only counts them so that it knows when the packet ends. The grant is held until the packet is complete. When both producers are requesting, the merger gives the link to them in turn.

Top module: `status_merge2`

## Requirements
- R1: After reset, `dn_req`, `a_start` and `b_start` are 0 and `dn_data` is 0.
- R2: While the merger is idle, a request on either source gives `dn_req` = 1 in the following cycle.
- R3: A `dn_start` pulse that arrives while `dn_req` is 1 appears in the same cycle on the start output of the granted source only. The other start output stays 0.
- R4: From the cycle of the accepted `dn_start`, `dn_data` equals the granted source's data for exactly `PKT_LEN` consecutive cycles.
- R5: Outside that forwarding window, `dn_data` is 0. This includes the cycles in which a source is granted but its packet has not yet been accepted.
- R6: `dn_req` is 0 from the cycle after the accepted `dn_start` until the packet ends.
- R7: When both sources are requesting at an idle cycle, the grant goes to the source that did not win the previous arbitration. Source A wins the first such arbitration after reset.
- R8: A request from the other source while a packet is in progress has no effect: `dn_req` stays 0, and the bytes of the granted source keep being forwarded.
- R9: A `dn_start` pulse while `dn_req` is 0 is ignored. Both start outputs stay 0 and `dn_data` stays 0.
- R10: After the last byte of a packet the merger is idle for one cycle, with `dn_req` = 0 and `dn_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_data | input | DW | Packet byte from source A |
| a_req | input | 1 | Source A has a packet to send |
| a_start | output | 1 | First byte of source A's packet accepted |
| b_data | input | DW | Packet byte from source B |
| b_req | input | 1 | Source B has a packet to send |
| b_start | output | 1 | First byte of source B's packet accepted |
| dn_data | output | DW | Byte forwarded downstream |
| dn_req | output | 1 | Downstream request |
| dn_start | input | 1 | Downstream accepts the first byte |

## Verification
The bench builds the merger with its defaults, `DW` = 8 and `PKT_LEN` = 5. With these values every byte slot of a full packet can be checked one cycle at a time. The bench sweeps every non-empty request pattern against acknowledge delays of 0 to 3 cycles, and runs that sweep twice. This makes the alternating priority switch back and forth many times, and it tests the competing request held through whole packets. Byte values encode both the source and the slot index, so a wrong owner, a slot that is off by one, or a leak outside the forwarding window each give a mismatch.

// File: rtl/status_merge2.sv
module status_merge2 #(
  parameter int DW      = 8,
  parameter int PKT_LEN = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_data,
  input  logic          a_req,
  output logic          a_start,
  input  logic [DW-1:0] b_data,
  input  logic          b_req,
  output logic          b_start,
  output logic [DW-1:0] dn_data,
  output logic          dn_req,
  input  logic          dn_start
);
  localparam int CW = (PKT_LEN < 2) ? 1 : $clog2(PKT_LEN);

  logic          busy, acked, owner, last_win;
  logic [CW-1:0] cnt;
  logic          waiting, accept, in_pkt, pick;

  assign waiting = busy && !acked;
  assign accept  = waiting && dn_start;
  assign in_pkt  = accept || acked;
  assign pick    = (a_req && b_req) ? !last_win : b_req;

  assign dn_req  = waiting;
  assign a_start = accept && !owner;
  assign b_start = accept && owner;
  assign dn_data = !in_pkt ? '0 : (owner ? b_data : a_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      acked    <= 1'b0;
      owner    <= 1'b0;
      last_win <= 1'b1;
      cnt      <= '0;
    end else if (!busy) begin
      if (a_req || b_req) begin
        busy     <= 1'b1;
        owner    <= pick;
        last_win <= pick;
      end
    end else if (accept) begin
      if (PKT_LEN == 1) begin
        busy <= 1'b0;
      end else begin
        acked <= 1'b1;
        cnt   <= CW'(1);
      end
    end else if (acked) begin
      if (cnt == CW'(PKT_LEN - 1)) begin
        busy  <= 1'b0;
        acked <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!dn_req && !a_start && !b_start && dn_data == '0));

  a_r2_grant_follows_req: assert property (@(posedge clk) disable iff (rst)
    (!busy && (a_req || b_req)) |=> dn_req);

  a_r3_start_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_start, b_start}));

  a_r9_start_needs_req: assert property (@(posedge clk) disable iff (rst)
    (a_start || b_start) |-> (dn_req && dn_start));

  a_r6_req_drops_after_accept: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_start) |=> !dn_req);

  a_r8_owner_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(owner));

  a_r5_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dn_data == '0));
endmodule

// File: tb/status_merge2_bench.sv
`timescale 1ns/1ps
module status_merge2_bench;
  localparam int DW = 8;
  localparam int PL = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic a_req = 1'b0, b_req = 1'b0, dn_start = 1'b0;
  logic a_start, b_start, dn_req;
  logic [DW-1:0] dn_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit exp_last = 1'b1;

  always #4 clk = ~clk;

  status_merge2 #(.DW(DW), .PKT_LEN(PL)) u_status_merge2 (
    .clk(clk), .rst(rst),
    .a_data(a_data), .a_req(a_req), .a_start(a_start),
    .b_data(b_data), .b_req(b_req), .b_start(b_start),
    .dn_data(dn_data), .dn_req(dn_req), .dn_start(dn_start)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_bytes(input int k);
    a_data = DW'(8'hA0 + k);
    b_data = DW'(8'h50 + k);
  endtask

  task automatic run_packet(input bit ra, input bit rb, input int dly);
    bit own;
    own = (ra && rb) ? !exp_last : rb;
    @(negedge clk);
    a_req = ra; b_req = rb;
    a_data = 8'h11; b_data = 8'h22;
    @(negedge clk); #1;
    check("R2 dn_req after request", dn_req, 1);
    check("R5 zero before accept", dn_data, 0);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk); #1;
      check("R2 dn_req held while waiting", dn_req, 1);
      check("R3 no start while waiting", {a_start, b_start}, 0);
    end
    @(negedge clk);
    set_bytes(0);
    dn_start = 1'b1;
    #1;
    check("R3 start to owner", {a_start, b_start}, own ? 1 : 2);
    check("R7 forwarded owner byte 0", dn_data, own ? 8'h50 : 8'hA0);
    for (int k = 1; k < PL; k++) begin
      @(negedge clk);
      dn_start = 1'b0;
      if (own) b_req = 1'b0; else a_req = 1'b0;
      set_bytes(k);
      #1;
      check("R4 byte forwarded", dn_data, own ? 8'h50 + k : 8'hA0 + k);
      check("R6 dn_req low in packet", dn_req, 0);
      if (ra && rb) check("R8 other request ignored", dn_req, 0);
    end
    @(negedge clk);
    set_bytes(9);
    #1;
    check("R10 idle dn_req", dn_req, 0);
    check("R10 idle dn_data", dn_data, 0);
    a_req = 1'b0; b_req = 1'b0;
    exp_last = own;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset dn_req", dn_req, 0);
    check("R1 reset starts", {a_start, b_start}, 0);
    check("R1 reset dn_data", dn_data, 0);
    rst = 1'b0;
    @(negedge clk);
    dn_start = 1'b1;
    a_data = 8'h33; b_data = 8'h44;
    #1;
    check("R9 stray start ignored", {a_start, b_start}, 0);
    check("R9 stray start no data", dn_data, 0);
    @(negedge clk);
    dn_start = 1'b0;
    #1;
    check("R9 no request after stray start", dn_req, 0);
    for (int rep = 0; rep < 2; rep++)
      for (int pat = 1; pat < 4; pat++)
        for (int d = 0; d < 4; d++)
          run_packet(pat[0], pat[1], d);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule